// File: doc/BRIEF.md
# OTP Word Serial Bit Readback

This block lets an external tester inspect the contents of a small one-time-programmable word array one bit at a time. Before any bit is addressed, a word-select input chooses one word. A seed strobe captures that choice and places a single 1 in the first stage of an addressing shift register. Each shift strobe then moves that 1 to the next stage, and each stage addresses one bit of the captured word.

While the walking 1 rests on a bit, a registered load-enable output is high if that bit is 1 and low if it is 0. An observer senses this level as extra supply current, so the block drives no data bus. After the pointer leaves the last stage, the register holds all zeros, load enable stays low and a done flag rises. The stored words are a plain register array that takes its values from a parameter at reset. There is no programming path.

Top module: `otp_bit_readback`

## Requirements
- R1: After reset, `ptr_o` is all zeros, `load_en_o` is 0 and `done_o` is 0.
- R2: A seed strobe clears the shift register and writes a 1 into the first stage. From the next cycle `ptr_o` equals 1 (bit 0 is the first stage) and `done_o` is 0. The seed also captures `word_sel` as the word to read.
- R3: Each shift strobe that arrives while the pointer is in stage k moves it to stage k+1, so `ptr_o` goes from bit k to bit k+1 one cycle later.
- R4: `load_en_o` is 1 exactly when the stage holding the pointer addresses a bit that stores 1. It changes in the same cycle as `ptr_o`. Bits are presented most significant first: stage k addresses bit WORD_W-1-k. For example, the word 110101 gives the sequence 1,1,0,1,0,1.
- R5: A shift from the last stage leaves `ptr_o` all zeros, `load_en_o` 0 and `done_o` 1. Further shift strobes, or shift strobes that arrive before any seed, change nothing.
- R6: A seed strobe in the middle of a walk restarts it at stage 0, so `ptr_o` is always one-hot or zero.
- R7: Changes on `word_sel` between seed strobes have no effect on the bits being presented.
- R8: When seed and shift strobes arrive in the same cycle, the seed wins and the pointer lands in stage 0.
- R9: In a cycle with neither strobe, `ptr_o`, `load_en_o` and `done_o` hold their values.
- R10: Word i holds bits CONTENTS[i*WORD_W +: WORD_W]. The defaults are: word 0 = 110101, word 1 = 001010, word 2 = 111111, word 3 = 000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_sel | input | $clog2(NUM_WORDS) | Word to read, captured on a seed strobe |
| seed_i | input | 1 | Clears the pointer register and loads a 1 into its first stage |
| shift_i | input | 1 | Advances the pointer by one stage |
| load_en_o | output | 1 | Registered level; high while the addressed bit is 1 |
| ptr_o | output | WORD_W | One-hot pointer position (bit 0 = first stage) |
| done_o | output | 1 | High once the pointer has left the last stage |

## Verification
The walk is tried on four words: a mixed word (110101), its complement-like word (001010), all ones and all zeros. Across these words every stage-to-bit mapping shows up with both levels, so an order that is reversed or shifted by one position is caught. Other patterns separate the remaining behaviours: seeding and shifting in the same cycle, seeding again in the middle of a walk, changing the selection during a walk, idle cycles between strobes, and shift strobes after the pointer has left the last stage or before any seed. Each of these tells apart correct priority, restart, capture, hold and exhaustion from a design that gets one of them wrong.

// File: rtl/otp_rb_pkg.sv
package otp_rb_pkg;

   // Map a pointer stage to the bit of the word it addresses.
   function automatic int unsigned stage_bit(input int unsigned stage,
                                             input int unsigned width,
                                             input bit msb_first);
      return msb_first ? (width - 1 - stage) : stage;
   endfunction

endpackage

// File: rtl/otp_word_array.sv
module otp_word_array #(
   parameter int unsigned WORD_W    = 6,
   parameter int unsigned NUM_WORDS = 4,
   parameter int unsigned SEL_W     = 2,
   parameter logic [NUM_WORDS*WORD_W-1:0] CONTENTS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] rd_word
);

   logic [WORD_W-1:0] cells [NUM_WORDS];

   // Storage: loaded at reset, never written afterwards.
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cells[w] <= CONTENTS[w*WORD_W +: WORD_W];
         else        cells[w] <= cells[w];
      end
   end

   // Read mux; a selection past the last word reads zeros.
   always_comb begin
      rd_word = '0;
      for (int w = 0; w < NUM_WORDS; w++) begin
         if (rd_sel == SEL_W'(w)) rd_word = cells[w];
      end
   end

endmodule

// File: rtl/otp_walk_shreg.sv
module otp_walk_shreg #(
   parameter int unsigned WORD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed,
   input  logic              shift,
   output logic [WORD_W-1:0] stages,
   output logic [WORD_W-1:0] stages_nxt,
   output logic              spent
);

   logic spent_nxt;

   // Per-stage next-value logic: seed clears and injects at stage 0,
   // shift moves each bit up by one stage.
   for (genvar k = 0; k < WORD_W; k++) begin : g_stage
      if (k == 0) begin : g_head
         assign stages_nxt[k] = seed ? 1'b1 : (shift ? 1'b0 : stages[k]);
      end else begin : g_body
         assign stages_nxt[k] = seed ? 1'b0 : (shift ? stages[k-1] : stages[k]);
      end
   end

   assign spent_nxt = seed ? 1'b0 : ((shift && stages[WORD_W-1]) ? 1'b1 : spent);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stages <= '0;
         spent  <= 1'b0;
      end else begin
         stages <= stages_nxt;
         spent  <= spent_nxt;
      end
   end

endmodule

// File: rtl/otp_load_drive.sv
module otp_load_drive #(
   parameter int unsigned WORD_W    = 6,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] stages_nxt,
   input  logic [WORD_W-1:0] word,
   output logic              load_en
);

   import otp_rb_pkg::*;

   logic [WORD_W-1:0] hit;

   // Stage-to-bit wiring is chosen at elaboration by the order option.
   for (genvar k = 0; k < WORD_W; k++) begin : g_hit
      localparam int unsigned BIT = stage_bit(k, WORD_W, MSB_FIRST);
      assign hit[k] = stages_nxt[k] & word[BIT];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_en <= 1'b0;
      else        load_en <= |hit;
   end

endmodule

// File: rtl/otp_bit_readback.sv
module otp_bit_readback #(
   parameter int unsigned WORD_W    = 6,
   parameter int unsigned NUM_WORDS = 4,
   parameter bit          MSB_FIRST = 1'b1,
   parameter logic [NUM_WORDS*WORD_W-1:0] CONTENTS = 24'b000000_111111_001010_110101,
   localparam int unsigned SEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  word_sel,
   input  logic              seed_i,
   input  logic              shift_i,
   output logic              load_en_o,
   output logic [WORD_W-1:0] ptr_o,
   output logic              done_o
);

   if (WORD_W < 2)    begin : g_bad_w $error("WORD_W must be at least 2"); end
   if (NUM_WORDS < 2) begin : g_bad_n $error("NUM_WORDS must be at least 2"); end

   logic [SEL_W-1:0]  sel_q;
   logic [SEL_W-1:0]  sel_nxt;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] stages_nxt;

   // The selection is captured only by a seed strobe.
   assign sel_nxt = seed_i ? word_sel : sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_nxt;
   end

   otp_word_array #(
      .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .SEL_W(SEL_W), .CONTENTS(CONTENTS)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .rd_sel(sel_nxt), .rd_word(word)
   );

   otp_walk_shreg #(.WORD_W(WORD_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .seed(seed_i), .shift(shift_i),
      .stages(ptr_o), .stages_nxt(stages_nxt), .spent(done_o)
   );

   otp_load_drive #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) u_drive (
      .clk(clk), .rst_n(rst_n), .stages_nxt(stages_nxt), .word(word),
      .load_en(load_en_o)
   );

endmodule

// File: rtl/otp_bit_readback_chk.sv
module otp_bit_readback_chk #(
   parameter int unsigned WORD_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seed_i,
   input logic              shift_i,
   input logic              load_en_o,
   input logic [WORD_W-1:0] ptr_o,
   input logic              done_o
);

   // R6
   ptr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ptr_o));

   // R2
   seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_i |=> (ptr_o == WORD_W'(1)) && !done_o);

   // R3
   shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_i && !seed_i && !ptr_o[WORD_W-1] && (ptr_o != '0))
      |=> (ptr_o == ($past(ptr_o) << 1)));

   // R5
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ptr_o == '0) && !load_en_o);

   // R4
   idle_ptr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_o == '0) |-> !load_en_o);

   // R9
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!seed_i && !shift_i) |=> $stable(ptr_o) && $stable(load_en_o) && $stable(done_o));

endmodule

bind otp_bit_readback otp_bit_readback_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .seed_i(seed_i), .shift_i(shift_i),
   .load_en_o(load_en_o), .ptr_o(ptr_o), .done_o(done_o)
);

// File: tb/otp_bit_readback_tb.sv
module otp_bit_readback_tb;

   localparam int W = 6;
   localparam int N = 4;
   localparam logic [N*W-1:0] MEM = 24'b000000_111111_001010_110101;

   typedef struct {
      logic [W-1:0] ptr;
      logic         le;
      logic         dn;
      string        req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] word_sel = '0;
   logic seed_i = 1'b0;
   logic shift_i = 1'b0;
   logic load_en_o;
   logic [W-1:0] ptr_o;
   logic done_o;

   int checks = 0;
   int errors = 0;
   exp_t q[$];

   // model state
   int m_pos = -1;
   int m_sel = 0;
   logic m_done = 1'b0;

   always #2.5 clk = ~clk;

   otp_bit_readback u_dut (
      .clk(clk), .rst_n(rst_n), .word_sel(word_sel), .seed_i(seed_i),
      .shift_i(shift_i), .load_en_o(load_en_o), .ptr_o(ptr_o), .done_o(done_o)
   );

   function automatic logic [W-1:0] word_of(int s);
      return MEM[s*W +: W];
   endfunction

   task automatic check(string req, logic [W-1:0] p, logic l, logic d,
                        logic [W-1:0] ep, logic el, logic ed);
      checks++;
      if (p !== ep || l !== el || d !== ed) begin
         errors++;
         $display("FAIL %s: ptr=%b le=%b done=%b expected ptr=%b le=%b done=%b",
                  req, p, l, d, ep, el, ed);
      end
   endtask

   // Driver: apply one cycle of stimulus at the falling edge and push the
   // expected outputs for the next rising edge.
   task automatic step(logic sd, logic sh, int sel, string req);
      exp_t e;
      @(negedge clk);
      seed_i = sd; shift_i = sh; word_sel = 2'(sel);
      if (sd) begin
         m_sel = sel; m_pos = 0; m_done = 1'b0;
      end else if (sh && m_pos >= 0 && m_pos < W) begin
         m_pos++;
         if (m_pos == W) m_done = 1'b1;
      end
      e.ptr = (m_pos >= 0 && m_pos < W) ? W'(1) << m_pos : '0;
      e.le  = (m_pos >= 0 && m_pos < W) ? word_of(m_sel)[W-1-m_pos] : 1'b0;
      e.dn  = m_done;
      e.req = req;
      q.push_back(e);
   endtask

   // Monitor: sample shortly after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.req, ptr_o, load_en_o, done_o, e.ptr, e.le, e.dn);
         end
      end
   end

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", ptr_o, load_en_o, done_o, '0, 1'b0, 1'b0);
      rst_n = 1'b1;
      step(0, 0, 0, "R9 idle before seed");
      step(0, 1, 0, "R5 shift before seed");
      // word 0 = 110101, full walk
      step(1, 0, 0, "R2 seed word0");
      for (int i = 0; i < W; i++) step(0, 1, 0, "R4 walk word0");
      step(0, 1, 0, "R5 shift after done");
      step(0, 0, 0, "R9 idle after done");
      // word 1 = 001010, selection wiggles mid-walk
      step(1, 0, 1, "R2 seed word1");
      step(0, 1, 3, "R7 sel change");
      step(0, 0, 2, "R9 hold mid-walk");
      step(0, 1, 0, "R7 sel change");
      step(0, 1, 1, "R3 walk word1");
      step(0, 1, 2, "R7 walk word1");
      step(0, 1, 3, "R5 walk word1 end");
      step(0, 1, 3, "R5 exhaust word1");
      // seed and shift together on word 2 = 111111
      step(1, 1, 2, "R8 seed beats shift");
      step(0, 1, 2, "R10 word2");
      step(0, 1, 2, "R10 word2");
      step(1, 0, 3, "R6 reseed mid-walk word3");
      for (int i = 0; i < W; i++) step(0, 1, 3, "R10 walk word3");
      // restart word 0 after done, partial walk
      step(1, 0, 0, "R6 reseed after done");
      step(0, 1, 0, "R4 word0 second bit");
      step(0, 1, 0, "R4 word0 third bit");
      step(0, 0, 0, "R9 idle");
      @(negedge clk);
      seed_i = 0; shift_i = 0;
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule